// File: doc/BRIEF.md
# BCD Clock and Calendar with Fractional 100 Hz Prescaler

This block keeps wall-clock time and the calendar date from a 4096 Hz enable strobe. A fractional prescaler turns that strobe into a 100 Hz tick. Single tick periods differ by one strobe, but the average rate is exact. Each tick advances a chain of packed-BCD counters: hundredths, seconds, minutes, hours, day of week, date of month, month and two-digit year. A century flag toggles each time the year wraps.

A host sets the time through a single-cycle load port. It gives a field selector and a data byte, and the new value appears on the outputs one clock later. All fields are visible on parallel outputs at all times. Hours run in either 24-hour or 12-hour format. The format is selected by a bit held in the hours field itself. Writing the hundredths field also realigns the prescaler, so a host can synchronise the sub-second phase to an outside event.

The prescaler is a two-state machine. `PS_LONG` divides by 41. `PS_SHORT` divides by 40. The transition `PS_LONG -> PS_SHORT` is taken at the end of the 24th long period. `PS_SHORT -> PS_LONG` is taken at the end of the short period. A hundredths write forces a restart to `PS_LONG` with both counters at zero.

Top module: `bcd_calendar`

## Requirements
- R1: `tick_100` is a one-clock pulse. It is registered in the same edge that advances the hundredths. Within each cycle of 25 ticks, the first 24 ticks come 41 accepted `tick_4k` strobes apart, and the 25th comes 40 strobes after the 24th.
- R2: Measured from a hundredths write or from reset, the 25th tick falls on exactly the 1024th accepted strobe.
- R3: `hsec` counts BCD 00 to 99. The tick that moves 99 to 00 also advances the seconds.
- R4: `sec` and `min` count BCD 00 to 59. A wrap to 00 advances the next field up.
- R5: When hours bit 6 is 0, the hours run in 24-hour format. Bits 5:0 count BCD 00 to 23, and the change from 23 to 00 advances the day.
- R6: When hours bit 6 is 1, the hours run in 12-hour format. Bit 5 is PM (1 = PM) and bits 4:0 hold BCD 01 to 12. The sequence is 12, 1 … 11. PM flips on the change from 11 to 12. The change from 11 PM to 12 AM advances the day.
- R7: The date wraps to 01 after the month's last day: 31, 30, or for February 28 or 29. A year is a leap year when its BCD value is a multiple of 4, and 00 counts as a leap year.
- R8: `dow` counts 1 to 7 and returns to 1. It advances once per day change.
- R9: `month` bits 4:0 hold BCD 01 to 12. The change from 12 to 01 advances the year. The change of `year` from 99 to 00 toggles `month` bit 7, the century flag.
- R10: When `wr_en` is high, `wr_sel` chooses the field and the field takes `wr_data` at the next edge. The codes are: 0 hundredths (8 bits), 1 seconds (bits 6:0), 2 minutes (bits 6:0), 3 hours (bits 6:0), 4 day of week (bits 2:0), 5 date (bits 5:0), 6 month (bit 7 century, bits 4:0 month), 7 year (8 bits). Codes 8 to 15 change nothing. A write wins over a count in the same cycle.
- R11: A hundredths write restarts the prescaler in its first long period. A strobe in that cycle is not counted. Writes to other fields leave the prescaler phase untouched.
- R12: After reset, the fields read as follows. Hundredths, seconds, minutes and hours are 00, in 24-hour format. Day of week is 1. Date is 01. Month is 01 with the century flag clear. Year is 00. `tick_100` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_4k | input | 1 | 4096 Hz enable strobe, one clock wide |
| wr_en | input | 1 | Field load request |
| wr_sel | input | 4 | Field selector (codes in R10) |
| wr_data | input | 8 | Value to load |
| tick_100 | output | 1 | 100 Hz tick pulse |
| hsec | output | 8 | Hundredths of a second, BCD |
| sec | output | 8 | Seconds, BCD, bit 7 reads 0 |
| min | output | 8 | Minutes, BCD, bit 7 reads 0 |
| hour | output | 8 | Hours with format and PM bits, bit 7 reads 0 |
| dow | output | 8 | Day of week 1 to 7 |
| date | output | 8 | Date of month, BCD |
| month | output | 8 | Century flag in bit 7, BCD month in bits 4:0 |
| year | output | 8 | Year, BCD |

## Verification
The bench preloads fields just before each rollover, and a behavioural model checks every output on every clock. The cases targeted are: February in years 23, 24 and 00; the ends of 30-day and 31-day months; the year wrap from 99 that flips the century; and the noon and midnight changes in 12-hour format. Each of these errors would show up as a one-cycle mismatch against the model:
- a wrong leap rule would produce a February 29 that should not exist, or skip one that should;
- a PM bit flipped at the 12-to-1 change instead of the 11-to-12 change would mark the afternoon as AM;
- a day carry taken at noon would advance the date twice a day.

The prescaler is timed from a hundredths write. A divider with a fixed ratio, or with the short period in the wrong place, moves the first tick away from strobe 41 or the 25th away from strobe 1024. Field writes land at every phase of a tick period. This catches a design that resets the phase on any write, or that lets a carry overwrite a value written in the same cycle.

// File: rtl/bcd_calendar_pkg.sv
package bcd_calendar_pkg;

    localparam int SEL_W = 4;

    typedef enum logic [SEL_W-1:0] {
        FLD_HSEC  = 4'd0,
        FLD_SEC   = 4'd1,
        FLD_MIN   = 4'd2,
        FLD_HOUR  = 4'd3,
        FLD_DOW   = 4'd4,
        FLD_DATE  = 4'd5,
        FLD_MONTH = 4'd6,
        FLD_YEAR  = 4'd7
    } field_e;

    // Two-digit packed BCD increment; 9 in the low digit carries to the high digit.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Multiple of four: ten is 2 mod 4, so an odd tens digit needs units 2 or 6.
    function automatic logic leap_bcd(input logic [7:0] y);
        if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    endfunction

    function automatic logic [5:0] last_day(input logic [4:0] mo, input logic [7:0] y);
        case (mo)
            5'h02:                      return leap_bcd(y) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

endpackage

// File: rtl/bcd_calendar_prescaler.sv
module bcd_calendar_prescaler #(
    parameter int DIV_LONG  = 41,
    parameter int DIV_SHORT = 40,
    parameter int LONG_RUNS = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_4k,
    input  logic restart,
    output logic adv
);
    localparam int CNT_W = $clog2(DIV_LONG);
    localparam int RUN_W = $clog2(LONG_RUNS);
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(DIV_LONG - 1);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(DIV_SHORT - 1);
    localparam logic [RUN_W-1:0] RUN_LAST   = RUN_W'(LONG_RUNS - 1);

    typedef enum logic [0:0] {PS_LONG, PS_SHORT} ps_e;

    ps_e             state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic [RUN_W-1:0] runs;
    logic             at_last;

    // next state
    always_comb begin
        state_nx = state;
        if (restart) begin
            state_nx = PS_LONG;
        end else begin
            unique case (state)
                PS_LONG:  if (adv && runs == RUN_LAST) state_nx = PS_SHORT;
                PS_SHORT: if (adv)                     state_nx = PS_LONG;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PS_LONG;
        else        state <= state_nx;
    end

    // outputs
    always_comb begin
        at_last = (state == PS_SHORT) ? (cnt == SHORT_LAST) : (cnt == LONG_LAST);
        adv     = en_4k && !restart && at_last;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt  <= '0;
            runs <= '0;
        end else if (en_4k) begin
            if (at_last) begin
                cnt <= '0;
                if (state == PS_LONG)
                    runs <= (runs == RUN_LAST) ? '0 : runs + RUN_W'(1);
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    // independent strobe count between ticks
    logic [CNT_W-1:0] obs_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n || restart || adv) obs_cnt <= '0;
        else if (en_4k)               obs_cnt <= obs_cnt + CNT_W'(1);
    end

    assert_period_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> (obs_cnt == LONG_LAST || obs_cnt == SHORT_LAST));

    assert_restart_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !(adv && obs_cnt != LONG_LAST));

endmodule

// File: rtl/bcd_calendar_time_chain.sv
module bcd_calendar_time_chain
    import bcd_calendar_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [7:0]       wr_data,
    output logic [7:0]       hsec,
    output logic [6:0]       sec,
    output logic [6:0]       min,
    output logic [6:0]       hour,
    output logic             day_carry
);
    logic       hs_wrap, sec_wrap, min_wrap;
    logic [6:0] hour_nx;
    logic [7:0] inc_s, inc_m, inc_h24, inc_h12;

    always_comb begin
        hs_wrap  = adv && (hsec == 8'h99);
        sec_wrap = hs_wrap && (sec == 7'h59);
        min_wrap = sec_wrap && (min == 7'h59);
        inc_s    = bcd_inc({1'b0, sec});
        inc_m    = bcd_inc({1'b0, min});
        inc_h24  = bcd_inc({1'b0, hour});
        inc_h12  = bcd_inc({3'b0, hour[4:0]});
        if (hour[6]) begin
            if (hour[4:0] == 5'h11)      hour_nx = {1'b1, ~hour[5], 5'h12};
            else if (hour[4:0] == 5'h12) hour_nx = {hour[6:5], 5'h01};
            else                         hour_nx = {hour[6:5], inc_h12[4:0]};
            day_carry = min_wrap && hour[5] && (hour[4:0] == 5'h11);
        end else begin
            hour_nx   = (hour == 7'h23) ? 7'h00 : inc_h24[6:0];
            day_carry = min_wrap && (hour == 7'h23);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsec <= '0;
            sec  <= '0;
            min  <= '0;
            hour <= '0;
        end else begin
            if (adv)      hsec <= hs_wrap  ? 8'h00 : bcd_inc(hsec);
            if (hs_wrap)  sec  <= sec_wrap ? 7'h00 : inc_s[6:0];
            if (sec_wrap) min  <= min_wrap ? 7'h00 : inc_m[6:0];
            if (min_wrap) hour <= hour_nx;
            if (wr_en) begin
                case (wr_sel)
                    FLD_HSEC: hsec <= wr_data;
                    FLD_SEC:  sec  <= wr_data[6:0];
                    FLD_MIN:  min  <= wr_data[6:0];
                    FLD_HOUR: hour <= wr_data[6:0];
                    default: ;
                endcase
            end
        end
    end

    logic wr_hs, wr_s, wr_h;
    assign wr_hs = wr_en && wr_sel == FLD_HSEC;
    assign wr_s  = wr_en && wr_sel == FLD_SEC;
    assign wr_h  = wr_en && wr_sel == FLD_HOUR;

    assert_hsec_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && hsec == 8'h99 && !wr_hs) |=> (hsec == 8'h00));

    assert_sec_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && hsec == 8'h99 && sec == 7'h59 && !wr_s) |=> (sec == 7'h00));

    assert_midnight24_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (min_wrap && hour == 7'h23 && !wr_h) |=> (hour == 7'h00));

    assert_noon12_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (min_wrap && hour == 7'h51 && !wr_h) |=> (hour == 7'h72));

    assert_load_sec_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_s |=> (sec == $past(wr_data[6:0])));

endmodule

// File: rtl/bcd_calendar_date_chain.sv
module bcd_calendar_date_chain
    import bcd_calendar_pkg::*;
#(
    parameter int DOW_LAST = 7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          day_carry,
    input  logic                          wr_en,
    input  logic [SEL_W-1:0]              wr_sel,
    input  logic [7:0]                    wr_data,
    output logic [$clog2(DOW_LAST+1)-1:0] dow,
    output logic [5:0]                    date,
    output logic [4:0]                    month,
    output logic                          century,
    output logic [7:0]                    year
);
    localparam int DOW_W = $clog2(DOW_LAST + 1);
    localparam logic [DOW_W-1:0] DOW_TOP = DOW_W'(DOW_LAST);

    logic       date_wrap, month_wrap, year_wrap;
    logic [7:0] inc_d, inc_mo;

    always_comb begin
        date_wrap  = day_carry && (date == last_day(month, year));
        month_wrap = date_wrap && (month == 5'h12);
        year_wrap  = month_wrap && (year == 8'h99);
        inc_d      = bcd_inc({2'b0, date});
        inc_mo     = bcd_inc({3'b0, month});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dow     <= DOW_W'(1);
            date    <= 6'h01;
            month   <= 5'h01;
            century <= 1'b0;
            year    <= 8'h00;
        end else begin
            if (day_carry)  dow   <= (dow == DOW_TOP) ? DOW_W'(1) : dow + DOW_W'(1);
            if (day_carry)  date  <= date_wrap ? 6'h01 : inc_d[5:0];
            if (date_wrap)  month <= month_wrap ? 5'h01 : inc_mo[4:0];
            if (month_wrap) year  <= year_wrap ? 8'h00 : bcd_inc(year);
            if (year_wrap)  century <= ~century;
            if (wr_en) begin
                case (wr_sel)
                    FLD_DOW:   dow  <= wr_data[DOW_W-1:0];
                    FLD_DATE:  date <= wr_data[5:0];
                    FLD_MONTH: begin
                        month   <= wr_data[4:0];
                        century <= wr_data[7];
                    end
                    FLD_YEAR:  year <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    logic wr_dw, wr_dt, wr_mo;
    assign wr_dw = wr_en && wr_sel == FLD_DOW;
    assign wr_dt = wr_en && wr_sel == FLD_DATE;
    assign wr_mo = wr_en && wr_sel == FLD_MONTH;

    assert_feb_leap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (day_carry && month == 5'h02 && date == 6'h28 && leap_bcd(year) && !wr_dt)
        |=> (date == 6'h29));

    assert_dow_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (day_carry && dow == DOW_TOP && !wr_dw) |=> (dow == DOW_W'(1)));

    assert_century_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (year_wrap && !wr_mo) |=> (century != $past(century)));

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import bcd_calendar_pkg::*;
#(
    parameter int DIV_LONG  = 41,
    parameter int DIV_SHORT = 40,
    parameter int LONG_RUNS = 24,
    parameter int DOW_LAST  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_4k,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [7:0]       wr_data,
    output logic             tick_100,
    output logic [7:0]       hsec,
    output logic [7:0]       sec,
    output logic [7:0]       min,
    output logic [7:0]       hour,
    output logic [7:0]       dow,
    output logic [7:0]       date,
    output logic [7:0]       month,
    output logic [7:0]       year
);
    localparam int DOW_W     = $clog2(DOW_LAST + 1);
    localparam int WINDOW_EN = DIV_LONG * LONG_RUNS + DIV_SHORT;
    localparam int WIN_W     = $clog2(WINDOW_EN + 1);
    localparam int TK_W      = $clog2(LONG_RUNS + 1);

    logic             adv, restart, day_carry, century;
    logic [6:0]       sec_r, min_r, hour_r;
    logic [DOW_W-1:0] dow_r;
    logic [5:0]       date_r;
    logic [4:0]       month_r;

    assign restart = wr_en && (wr_sel == FLD_HSEC);

    bcd_calendar_prescaler #(
        .DIV_LONG (DIV_LONG),
        .DIV_SHORT(DIV_SHORT),
        .LONG_RUNS(LONG_RUNS)
    ) u_prescaler (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_4k  (tick_4k),
        .restart(restart),
        .adv    (adv)
    );

    bcd_calendar_time_chain u_time (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .hsec     (hsec),
        .sec      (sec_r),
        .min      (min_r),
        .hour     (hour_r),
        .day_carry(day_carry)
    );

    bcd_calendar_date_chain #(.DOW_LAST(DOW_LAST)) u_date (
        .clk      (clk),
        .rst_n    (rst_n),
        .day_carry(day_carry),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .dow      (dow_r),
        .date     (date_r),
        .month    (month_r),
        .century  (century),
        .year     (year)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) tick_100 <= 1'b0;
        else        tick_100 <= adv;
    end

    assign sec   = {1'b0, sec_r};
    assign min   = {1'b0, min_r};
    assign hour  = {1'b0, hour_r};
    assign dow   = 8'(dow_r);
    assign date  = {2'b0, date_r};
    assign month = {century, 2'b0, month_r};

    // strobes across one full 25-tick window
    logic [WIN_W-1:0] win_en;
    logic [TK_W-1:0]  win_tk;
    always_ff @(posedge clk) begin
        if (!rst_n || restart || (adv && win_tk == TK_W'(LONG_RUNS))) begin
            win_en <= '0;
            win_tk <= '0;
        end else begin
            if (tick_4k) win_en <= win_en + WIN_W'(1);
            if (adv)     win_tk <= win_tk + TK_W'(1);
        end
    end

    assert_window_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && win_tk == TK_W'(LONG_RUNS)) |-> (win_en + WIN_W'(1) == WIN_W'(WINDOW_EN)));

    assert_tick_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_100 |=> !tick_100);

endmodule

// File: tb/bcd_calendar_bench.sv
module bcd_calendar_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_4k = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic       tick_100;
    logic [7:0] hsec, sec, min, hour, dow, date, month, year;

    always #10 clk = ~clk;

    bcd_calendar u_bcd_calendar (
        .clk(clk), .rst_n(rst_n), .tick_4k(tick_4k), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .tick_100(tick_100),
        .hsec(hsec), .sec(sec), .min(min), .hour(hour), .dow(dow),
        .date(date), .month(month), .year(year)
    );

    int total = 0;
    int failed = 0;
    int en_mode = 1;
    int cyc = 0;
    int wd = 0;
    bit cmp_on = 0;

    // behavioural reference state
    int m_hs, m_s, m_m, m_hr, m_dw, m_dt, m_mo, m_yr, m_pc, m_ph;
    bit m_h12, m_pm, m_cen, m_tick;

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int unbcd(input logic [7:0] x);
        return int'(x[7:4]) * 10 + int'(x[3:0]);
    endfunction

    function automatic int dim(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] exp_hour();
        logic [7:0] b;
        b = bcd(m_hr);
        if (m_h12) return {1'b0, 1'b1, m_pm, b[4:0]};
        return b;
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            failed++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        m_hs = 0; m_s = 0; m_m = 0; m_hr = 0; m_h12 = 0; m_pm = 0;
        m_dw = 1; m_dt = 1; m_mo = 1; m_cen = 0; m_yr = 0;
        m_pc = 0; m_ph = 0; m_tick = 0;
    endtask

    task automatic model_step();
        bit adv = 0;
        bit dayc = 0;
        int n_hs = m_hs, n_s = m_s, n_m = m_m, n_hr = m_hr, n_dw = m_dw;
        int n_dt = m_dt, n_mo = m_mo, n_yr = m_yr;
        bit n_h12 = m_h12, n_pm = m_pm, n_cen = m_cen;
        if (wr_en && wr_sel == 4'd0) begin
            m_pc = 0; m_ph = 0;
        end else if (tick_4k) begin
            if (m_pc == ((m_ph == 24) ? 39 : 40)) begin
                adv = 1; m_pc = 0; m_ph = (m_ph + 1) % 25;
            end else m_pc++;
        end
        m_tick = adv;
        if (adv) begin
            if (m_hs == 99) begin
                n_hs = 0;
                if (m_s == 59) begin
                    n_s = 0;
                    if (m_m == 59) begin
                        n_m = 0;
                        if (m_h12) begin
                            if (m_hr == 11) begin n_hr = 12; n_pm = !m_pm; dayc = m_pm; end
                            else if (m_hr == 12) n_hr = 1;
                            else n_hr = m_hr + 1;
                        end else begin
                            if (m_hr == 23) begin n_hr = 0; dayc = 1; end
                            else n_hr = m_hr + 1;
                        end
                    end else n_m = m_m + 1;
                end else n_s = m_s + 1;
            end else n_hs = m_hs + 1;
        end
        if (dayc) begin
            n_dw = (m_dw == 7) ? 1 : m_dw + 1;
            if (m_dt == dim(m_mo, m_yr)) begin
                n_dt = 1;
                if (m_mo == 12) begin
                    n_mo = 1;
                    if (m_yr == 99) begin n_yr = 0; n_cen = !m_cen; end
                    else n_yr = m_yr + 1;
                end else n_mo = m_mo + 1;
            end else n_dt = m_dt + 1;
        end
        if (wr_en) begin
            case (wr_sel)
                4'd0: n_hs = unbcd(wr_data);
                4'd1: n_s  = unbcd({1'b0, wr_data[6:0]});
                4'd2: n_m  = unbcd({1'b0, wr_data[6:0]});
                4'd3: begin
                    n_h12 = wr_data[6];
                    if (wr_data[6]) begin n_pm = wr_data[5]; n_hr = unbcd({3'b0, wr_data[4:0]}); end
                    else begin n_pm = 0; n_hr = unbcd({2'b0, wr_data[5:0]}); end
                end
                4'd4: n_dw = int'(wr_data[2:0]);
                4'd5: n_dt = unbcd({2'b0, wr_data[5:0]});
                4'd6: begin n_mo = unbcd({3'b0, wr_data[4:0]}); n_cen = wr_data[7]; end
                4'd7: n_yr = unbcd(wr_data);
                default: ;
            endcase
        end
        m_hs = n_hs; m_s = n_s; m_m = n_m; m_hr = n_hr; m_h12 = n_h12; m_pm = n_pm;
        m_dw = n_dw; m_dt = n_dt; m_mo = n_mo; m_yr = n_yr; m_cen = n_cen;
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else        model_step();
    end

    // strobe pattern and per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        cyc++;
        tick_4k <= (en_mode != 0) && (cyc % (en_mode == 0 ? 1 : en_mode) == 0);
        if (cmp_on && rst_n) begin
            chk("R1 R11 tick_100", int'(tick_100), int'(m_tick));
            chk("R3 hsec", hsec, bcd(m_hs));
            chk("R4 sec", sec, bcd(m_s));
            chk("R4 min", min, bcd(m_m));
            chk("R5 R6 hour", hour, exp_hour());
            chk("R8 dow", dow, m_dw);
            chk("R7 date", date, bcd(m_dt));
            chk("R9 month", month, {m_cen, 2'b0, 5'(bcd(m_mo))});
            chk("R9 year", year, bcd(m_yr));
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            total++;
            failed++;
            $display("FAIL watchdog all requirements got timeout expected completion");
            finish_run();
        end
    end

    task automatic wr(input logic [3:0] s, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_eve(input logic [7:0] yr, input logic [7:0] mo, input logic [7:0] dt,
                           input logic [7:0] hr);
        wr(4'd7, yr); wr(4'd6, mo); wr(4'd5, dt); wr(4'd3, hr);
        wr(4'd2, 8'h59); wr(4'd1, 8'h59); wr(4'd0, 8'h98);
        idle(120);
    endtask

    initial begin
        idle(5);
        // R12 reset values while reset is held
        chk("R12 tick_100", tick_100, 0);
        chk("R12 hsec", hsec, 8'h00);
        chk("R12 sec", sec, 8'h00);
        chk("R12 min", min, 8'h00);
        chk("R12 hour", hour, 8'h00);
        chk("R12 dow", dow, 8'h01);
        chk("R12 date", date, 8'h01);
        chk("R12 month", month, 8'h01);
        chk("R12 year", year, 8'h00);
        rst_n = 1'b1;
        cmp_on = 1;

        // R2 and R11: tick placement after a hundredths write, strobe every clock
        en_mode = 1;
        begin
            int ticks = 0, first = 0, last = 0;
            wr(4'd0, 8'h00);
            for (int k = 1; k <= 1100; k++) begin
                @(negedge clk);
                if (tick_100) begin
                    ticks++;
                    if (ticks == 1)  first = k;
                    if (ticks == 25) last = k;
                end
            end
            chk("R11 first tick after hundredths write", first, 41);
            chk("R2 25th tick strobe count", last, 1024);
        end

        // sparse strobes
        en_mode = 3;
        idle(2500);
        en_mode = 1;

        // R9 full rollover with century toggle
        wr(4'd4, 8'h07);
        set_eve(8'h99, 8'h92, 8'h31, 8'h23);
        chk("R9 century toggled and year wrapped", {month, year}, 16'h0100);
        chk("R8 dow wrapped", dow, 8'h01);

        // R7 month ends
        set_eve(8'h23, 8'h02, 8'h28, 8'h23);
        chk("R7 non-leap February", {month, date}, 16'h0301);
        set_eve(8'h24, 8'h02, 8'h28, 8'h23);
        chk("R7 leap February 29", {month, date}, 16'h0229);
        set_eve(8'h24, 8'h02, 8'h29, 8'h23);
        chk("R7 leap February end", {month, date}, 16'h0301);
        set_eve(8'h00, 8'h02, 8'h28, 8'h23);
        chk("R7 year 00 leap", date, 8'h29);
        set_eve(8'h25, 8'h04, 8'h30, 8'h23);
        chk("R7 30-day month", {month, date}, 16'h0501);
        set_eve(8'h25, 8'h01, 8'h30, 8'h23);
        chk("R7 31-day month", date, 8'h31);
        set_eve(8'h50, 8'h12, 8'h31, 8'h23);
        chk("R9 year advance", year, 8'h51);

        // R5 and R6 hour formats
        set_eve(8'h25, 8'h05, 8'h10, 8'h51);
        chk("R6 11AM to 12PM", hour, 8'h72);
        set_eve(8'h25, 8'h05, 8'h10, 8'h72);
        chk("R6 12PM to 1PM", hour, 8'h61);
        set_eve(8'h25, 8'h05, 8'h10, 8'h71);
        chk("R6 11PM to 12AM", hour, 8'h52);
        chk("R6 day carry at 12AM", date, 8'h11);
        set_eve(8'h25, 8'h05, 8'h10, 8'h52);
        chk("R6 12AM to 1AM", hour, 8'h41);
        set_eve(8'h25, 8'h05, 8'h10, 8'h49);
        chk("R6 9AM to 10AM", hour, 8'h50);
        set_eve(8'h25, 8'h05, 8'h10, 8'h19);
        chk("R5 19 to 20", {hour, date}, 16'h2010);

        // R10 ignored selector codes, strobes stopped
        en_mode = 0;
        idle(4);
        begin
            logic [63:0] snap;
            snap = {hsec, sec, min, hour, dow, date, month, year};
            for (int s = 8; s < 16; s++) wr(4'(s), 8'h33);
            idle(2);
            chk("R10 codes 8-15 ignored", ({hsec, sec, min, hour, dow, date, month, year} == snap), 1);
        end
        wr(4'd1, 8'h42);
        idle(1);
        chk("R10 seconds load", sec, 8'h42);

        // R11 writes to other fields at every phase of a tick period
        en_mode = 1;
        for (int k = 0; k < 45; k++) begin
            wr(4'd2, 8'h30);
            idle(k % 7);
        end
        idle(300);

        finish_run();
    end

endmodule